// File: doc/BRIEF.md
# USB Suspend and Remote-Wakeup Controller

This block sits beside the line-state logic of a full-speed USB device controller. It measures how long the bus has been idle and declares suspend after more than 3 ms of unbroken idle. It then lets a local microcontroller request a remote wakeup. The block drives a resume (K-state) enable for a fixed time. That drive begins at once if the bus has already been idle for 5 ms. If the request comes earlier, the drive is held back until the 5 ms mark.

The block also keeps two interrupt status bits. The suspend-entry status sits at bit 6 and the bus-reset status at bit 5. Both feed one interrupt line through per-bit enables. The microcontroller reaches the block through a small register port with a write strobe, a 2-bit address, write data and combinational read data. Register map: address 0 is control, address 1 is interrupt status, address 2 is interrupt enable, and address 3 reads zero. All durations are set as millisecond parameters scaled by the clock rate in kHz.

Top module: `usb_susp_ctrl`

## Requirements
- R1: The idle counter clears on any cycle with `bus_idle` low. After SUSP_MS*CLK_KHZ+1 consecutive idle cycles, `susp_o` is 1. One cycle earlier it is still 0.
- R2: The clock edge that sets `susp_o` also sets interrupt status bit 6 (`stat_susp_o`). While that bit's enable is set, `irq_o` goes high.
- R3: An `eop_det` pulse clears `susp_o` and the remote-wakeup bit on the next edge.
- R4: Writing 1 to control bit 1 sets `rwake_o` only while `susp_o` is 1. The same write made outside suspend leaves `rwake_o` at 0 and `drive_k_o` at 0.
- R5: Suppose `rwake_o` is set before idle reaches WAKE_MS*CLK_KHZ cycles. Then `drive_k_o` rises on the edge after the idle count reaches that value, and not before.
- R6: Suppose the remote-wakeup write lands when idle has already reached WAKE_MS*CLK_KHZ cycles. Then `drive_k_o` is 1 right after that write's edge.
- R7: `drive_k_o` stays high for exactly RESUME_MS*CLK_KHZ cycles and then drops. It does not rise again for the same request.
- R8: A `resume_det` pulse clears both `susp_o` and `rwake_o` on the next edge.
- R9: A `bus_rst_det` pulse sets status bit 5. Writing 1 to control bit 2 clears it. If the set and the clear come in the same cycle, the set wins.
- R10: Control bit 2 always reads 0. A write with a data bit at 0 leaves the state behind that bit unchanged.
- R11: `irq_o` is the OR of (status AND enable) over bits 6 and 5. Both enables reset to 1, so the enable register reads 0x60. Writing 1 to status bit 6 clears the suspend status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle | input | 1 | Bus is in the idle line state this cycle |
| eop_det | input | 1 | End-of-packet received (1-cycle strobe) |
| resume_det | input | 1 | Resume signalling from the host detected (strobe) |
| bus_rst_det | input | 1 | Bus reset detected (strobe) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| susp_o | output | 1 | Suspend status |
| rwake_o | output | 1 | Remote-wakeup request pending |
| drive_k_o | output | 1 | Enable for driving resume K-state |
| stat_susp_o | output | 1 | Suspend-entry interrupt status (bit 6) |
| stat_brst_o | output | 1 | Bus-reset interrupt status (bit 5) |
| irq_o | output | 1 | Interrupt request |

## Verification
The stimulus goes in at the falling edge and the results are read at the next falling edge, so every check sees the state after a known number of rising edges. The idle counter adds one rising edge between the counter reaching a threshold and the registered result. Suspend therefore appears after edge SUSP+1 of idle, and a held-back resume drive appears at edge WAKE+1. A status bit, a remote-wakeup set, a late-request drive and a strobe-driven clear all take effect on the edge that samples their stimulus. The bench counts edges from the start of each idle run and checks the output one edge before each deadline and on the deadline itself.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef logic [1:0] reg_addr_t;

  localparam reg_addr_t ADDR_CTRL  = 2'd0;
  localparam reg_addr_t ADDR_STAT  = 2'd1;
  localparam reg_addr_t ADDR_INTEN = 2'd2;

  localparam int CTRL_SUSP  = 0;
  localparam int CTRL_RWAKE = 1;
  localparam int CTRL_BRCLR = 2;

  localparam int STAT_BRST = 5;
  localparam int STAT_SUSP = 6;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int SUSP_CYC = 12,
  parameter int WAKE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_idle,
  output logic susp_hit,
  output logic wake_ok
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!bus_idle)
      cnt_d = '0;
    else if (cnt_q != CW'(WAKE_CYC))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign susp_hit = (cnt_q == CW'(SUSP_CYC));
  assign wake_ok  = (cnt_q == CW'(WAKE_CYC));

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> !susp_hit && !wake_ok);
endmodule

// File: rtl/usb_wake_ctrl.sv
module usb_wake_ctrl #(
  parameter int RES_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr,
  input  logic wake_ok,
  output logic rwake,
  output logic drive_k
);
  localparam int DW = $clog2(RES_CYC + 1);

  logic          rwake_q, rwake_d;
  logic          fired_q, fired_d;
  logic          drive_q, drive_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          start;

  assign start = (rwake_q | set_req) & ~fired_q & ~drive_q & wake_ok & ~clr;

  always_comb begin
    rwake_d = rwake_q;
    fired_d = fired_q;
    drive_d = drive_q;
    dcnt_d  = dcnt_q;
    if (clr) begin
      rwake_d = 1'b0;
      fired_d = 1'b0;
      drive_d = 1'b0;
    end else begin
      if (set_req) rwake_d = 1'b1;
      if (start) begin
        drive_d = 1'b1;
        fired_d = 1'b1;
        dcnt_d  = DW'(RES_CYC - 1);
      end else if (drive_q) begin
        if (dcnt_q == '0) drive_d = 1'b0;
        else              dcnt_d  = dcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwake_q <= 1'b0;
      fired_q <= 1'b0;
      drive_q <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      rwake_q <= rwake_d;
      fired_q <= fired_d;
      drive_q <= drive_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign rwake   = rwake_q;
  assign drive_k = drive_q;

  // R7
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> rwake_q);

  // R8
  clr_stops_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rwake_q && !drive_q);
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_susp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       susp_set,
  input  logic       brst_set,
  input  logic       wr,
  input  reg_addr_t  addr,
  input  logic [7:0] wdata,
  output logic       stat_susp,
  output logic       stat_brst,
  output logic [1:0] en,
  output logic       irq
);
  logic       ss_q, ss_d;
  logic       sb_q, sb_d;
  logic [1:0] en_q, en_d;
  logic       ctrl_wr, stat_wr, en_wr;

  assign ctrl_wr = wr & (addr == ADDR_CTRL);
  assign stat_wr = wr & (addr == ADDR_STAT);
  assign en_wr   = wr & (addr == ADDR_INTEN);

  always_comb begin
    ss_d = ss_q;
    sb_d = sb_q;
    en_d = en_q;
    if (susp_set)                            ss_d = 1'b1;
    else if (stat_wr && wdata[STAT_SUSP])    ss_d = 1'b0;
    if (brst_set)                            sb_d = 1'b1;
    else if (ctrl_wr && wdata[CTRL_BRCLR])   sb_d = 1'b0;
    if (en_wr) en_d = {wdata[STAT_SUSP], wdata[STAT_BRST]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= 1'b0;
      sb_q <= 1'b0;
      en_q <= 2'b11;
    end else begin
      ss_q <= ss_d;
      sb_q <= sb_d;
      en_q <= en_d;
    end
  end

  assign stat_susp = ss_q;
  assign stat_brst = sb_q;
  assign en        = en_q;
  assign irq       = (ss_q & en_q[1]) | (sb_q & en_q[0]);

  // R9
  brst_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brst_set |=> sb_q);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_q && !sb_q) |-> !irq);
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int CLK_KHZ   = 48000,
  parameter int SUSP_MS   = 3,
  parameter int WAKE_MS   = 5,
  parameter int RESUME_MS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_idle,
  input  logic       eop_det,
  input  logic       resume_det,
  input  logic       bus_rst_det,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       susp_o,
  output logic       rwake_o,
  output logic       drive_k_o,
  output logic       stat_susp_o,
  output logic       stat_brst_o,
  output logic       irq_o
);
  localparam int SUSP_CYC = CLK_KHZ * SUSP_MS;
  localparam int WAKE_CYC = CLK_KHZ * WAKE_MS;
  localparam int RES_CYC  = CLK_KHZ * RESUME_MS;

  logic       susp_hit, wake_ok;
  logic       susp_q, susp_d;
  logic       leave, enter, wake_wr;
  logic [1:0] en;

  usb_idle_timer #(.SUSP_CYC(SUSP_CYC), .WAKE_CYC(WAKE_CYC)) idle_i (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
    .susp_hit(susp_hit), .wake_ok(wake_ok)
  );

  assign leave   = eop_det | resume_det;
  assign enter   = susp_hit & ~susp_q & ~leave;
  assign wake_wr = reg_wr & (reg_addr == ADDR_CTRL) & reg_wdata[CTRL_RWAKE] & susp_q;

  always_comb begin
    susp_d = susp_q;
    if (leave)      susp_d = 1'b0;
    else if (enter) susp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_q <= 1'b0;
    else        susp_q <= susp_d;
  end

  usb_wake_ctrl #(.RES_CYC(RES_CYC)) wake_i (
    .clk(clk), .rst_n(rst_n), .set_req(wake_wr), .clr(leave),
    .wake_ok(wake_ok), .rwake(rwake_o), .drive_k(drive_k_o)
  );

  usb_irq_regs irq_i (
    .clk(clk), .rst_n(rst_n), .susp_set(enter), .brst_set(bus_rst_det),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .stat_susp(stat_susp_o), .stat_brst(stat_brst_o), .en(en), .irq(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_SUSP]  = susp_q;
        reg_rdata[CTRL_RWAKE] = rwake_o;
      end
      ADDR_STAT: begin
        reg_rdata[STAT_SUSP] = stat_susp_o;
        reg_rdata[STAT_BRST] = stat_brst_o;
      end
      ADDR_INTEN: begin
        reg_rdata[STAT_SUSP] = en[1];
        reg_rdata[STAT_BRST] = en[0];
      end
      default: reg_rdata = '0;
    endcase
  end

  assign susp_o = susp_q;

  // R1
  susp_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(bus_idle));

  // R2
  susp_flags_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> stat_susp_o);

  // R4
  rwake_only_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwake_o) |-> $past(susp_q));

  // R8
  resume_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_det |=> !susp_q && !rwake_o);
endmodule

// File: tb/usb_susp_ctrl_tb.sv
module usb_susp_ctrl_tb_top;
  localparam int CLK_KHZ = 4;
  localparam int SUSP = CLK_KHZ * 3;
  localparam int WAKE = CLK_KHZ * 5;
  localparam int RES  = CLK_KHZ * 2;

  logic clk = 1'b0;
  logic rst_n, bus_idle, eop_det, resume_det, bus_rst_det, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic susp_o, rwake_o, drive_k_o, stat_susp_o, stat_brst_o, irq_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  usb_susp_ctrl #(.CLK_KHZ(CLK_KHZ), .SUSP_MS(3), .WAKE_MS(5), .RESUME_MS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .eop_det(eop_det),
    .resume_det(resume_det), .bus_rst_det(bus_rst_det), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .susp_o(susp_o), .rwake_o(rwake_o), .drive_k_o(drive_k_o),
    .stat_susp_o(stat_susp_o), .stat_brst_o(stat_brst_o), .irq_o(irq_o)
  );

  // {wr, addr[1:0], data[7:0], brst, exp_irq, exp_rdata[7:0]}
  localparam logic [20:0] VECS [0:8] = '{
    {1'b0, 2'd1, 8'h00, 1'b1, 1'b1, 8'h20},  // R9 set
    {1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00},  // R10 zero write
    {1'b1, 2'd0, 8'h04, 1'b0, 1'b0, 8'h00},  // R9 clear, R10 reads 0
    {1'b0, 2'd1, 8'h00, 1'b1, 1'b1, 8'h20},  // R9 set again
    {1'b1, 2'd2, 8'h40, 1'b0, 1'b0, 8'h40},  // R11 masked
    {1'b1, 2'd2, 8'h60, 1'b0, 1'b1, 8'h60},  // R11 unmasked
    {1'b1, 2'd0, 8'h04, 1'b1, 1'b1, 8'h00},  // R9 set wins
    {1'b1, 2'd0, 8'h04, 1'b0, 1'b0, 8'h00},  // R9 clear
    {1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00}   // R9 status empty
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic pulse_leave(input logic is_eop);
    if (is_eop) eop_det = 1'b1; else resume_det = 1'b1;
    tick();
    eop_det = 1'b0; resume_det = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_idle = 1'b0; eop_det = 1'b0; resume_det = 1'b0;
    bus_rst_det = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk("reset susp", susp_o, 0);
    chk("reset drive", drive_k_o, 0);
    chk("reset irq", irq_o, 0);
    reg_addr = 2'd2;
    #0 chk("R11 enable reset", reg_rdata, 8'h60);
    reg_addr = 2'd0;

    // R1: an idle break restarts the count
    bus_idle = 1'b1;
    repeat (10) tick();
    bus_idle = 1'b0;
    tick();
    bus_idle = 1'b1;
    repeat (SUSP) tick();
    chk("R1 not yet", susp_o, 0);
    tick();
    chk("R1 suspend", susp_o, 1);
    chk("R2 stat", stat_susp_o, 1);
    chk("R2 irq", irq_o, 1);

    // R5: early request, edge SUSP+2
    wr(2'd0, 8'h02);
    chk("R4 rwake set", rwake_o, 1);
    for (int i = SUSP + 2; i < WAKE; i++) begin
      tick();
      chk("R5 held", drive_k_o, 0);
    end
    tick();
    chk("R5 drive", drive_k_o, 1);
    for (int i = 1; i < RES; i++) begin
      tick();
      chk("R7 hold", drive_k_o, 1);
    end
    tick();
    chk("R7 release", drive_k_o, 0);
    repeat (3) begin
      tick();
      chk("R7 no repeat", drive_k_o, 0);
    end

    // R8
    pulse_leave(1'b0);
    chk("R8 susp", susp_o, 0);
    chk("R8 rwake", rwake_o, 0);

    // R4: outside suspend
    wr(2'd0, 8'h02);
    chk("R4 ignored", rwake_o, 0);
    chk("R4 no drive", drive_k_o, 0);

    // R6: late request
    bus_idle = 1'b0;
    tick();
    bus_idle = 1'b1;
    repeat (SUSP + 1) tick();
    chk("R6 suspend", susp_o, 1);
    repeat (10) tick();
    wr(2'd0, 8'h02);
    chk("R6 drive now", drive_k_o, 1);

    // R3
    pulse_leave(1'b1);
    chk("R3 susp", susp_o, 0);
    chk("R3 rwake", rwake_o, 0);
    chk("R3 drive", drive_k_o, 0);

    // R11: clear suspend status
    chk("R11 pending", irq_o, 1);
    wr(2'd1, 8'h00);
    chk("R10 zero keeps", stat_susp_o, 1);
    wr(2'd1, 8'h40);
    chk("R11 cleared", irq_o, 0);

    // vector table
    for (int k = 0; k < 9; k++) begin
      reg_wr = VECS[k][20];
      reg_addr = VECS[k][19:18];
      reg_wdata = VECS[k][17:10];
      bus_rst_det = VECS[k][9];
      tick();
      reg_wr = 1'b0; bus_rst_det = 1'b0;
      chk($sformatf("R9 vec%0d irq", k), irq_o, VECS[k][8]);
      chk($sformatf("R10 vec%0d rdata", k), reg_rdata, VECS[k][7:0]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule